// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Logic Array

This block is a small programmable logic array with three inputs, four shared product terms and two outputs. The AND plane and the OR plane are both set by configuration bits. Any product term may use the true literal, the complemented literal, or neither for each input. Any product term may feed any output.

Only the four selected product terms are formed. The block does not decode all eight minterms of the inputs. Each output has a polarity bit, applied after its OR term, so the output is either the sum of products or its complement. The path from the inputs to the outputs is purely combinational.

The 34 configuration bits are loaded through a serial shift chain, most significant bit first, while a load enable is high. The bits are held in registers. A one-cycle strobe then arms the outputs. Until the outputs are armed they read 0.

Top module: `sop_array`

## Requirements
- R1: When rst_n is low at a rising edge of clk, all 34 configuration bits and the armed flag are cleared, so f_out reads 2'b00.
- R2: When cfg_en is high at a rising edge, the configuration word shifts one place toward its MSB and takes cfg_bit into bit 0. After 34 such edges, the first bit shifted in sits at bit 33.
- R3: When cfg_en is low, the configuration word does not change, whatever cfg_bit does.
- R4: f_out is 2'b00 until cfg_done has been high at a rising edge after reset. From then on the outputs stay armed until the next reset.
- R5: In the configuration word, term t (0..3) and input bit i (0..2) have a true-literal bit at position 10+6t+2i and a complement-literal bit at position 11+6t+2i. A product term is the AND of all the literals connected to it.
- R6: If both literal bits of one input are set for a term, that term is 0 for every input pattern.
- R7: A term with no literal connected is 1, but it affects an output only when the OR bit for that output is set.
- R8: The OR bit for term t and output o is at position 2+4o+t. The sum for an output is the OR of its selected terms, and it is 0 when no term is selected.
- R9: The polarity bit for output o is at position o. A value of 1 inverts that output's sum, and 0 passes it through unchanged.
- R10: Once armed, f_out follows a change on in_vec with no clock edge in between.
- R11: With A=in_vec[2], B=in_vec[1] and C=in_vec[0], the reference configuration gives f_out[0] = AB' + AC + A'BC' and f_out[1] = (AC + BC)'. In this configuration the term AC is shared by both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_done | input | 1 | Strobe that arms the outputs |
| in_vec | input | 3 | Logic inputs {A,B,C} |
| f_out | output | 2 | Configured outputs {F2,F1} |

## Verification
The reference configuration is applied to all eight input combinations. Together these separate each product term and show that the shared term drives both outputs, one of them inverted. Before arming and after a reset, the same sweep must read all zeros. This distinguishes a missing gate from a zero sum. Separate patterns cover a term with no literals, a term with conflicting literals, an output with no selected terms, and both settings of the polarity bits. Cycling cfg_bit with the enable low, followed by a full sweep, shows that the stored configuration is not disturbed.

// File: rtl/sop_array_pkg.sv
// Shared defaults and helpers for the sum-of-products array.
// Assumes: configuration word = AND bits (high), OR bits, polarity bits (low).
package sop_array_pkg;
    localparam int unsigned DEF_INPUTS = 3;
    localparam int unsigned DEF_TERMS  = 4;
    localparam int unsigned DEF_OUTS   = 2;

    // Total number of configuration bits for a given array shape.
    function automatic int unsigned chain_len(int unsigned n_in, int unsigned n_term,
                                              int unsigned n_out);
        return 2 * n_in * n_term + n_term * n_out + n_out;
    endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
// Serial configuration register and arming flag.
// Shifts toward the MSB while cfg_en is high; cfg_done arms the outputs.
// Assumes a synchronous active-low reset that clears everything.
module sop_cfg_chain #(
    parameter int unsigned W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_bit,
    input  logic         cfg_done,
    output logic [W-1:0] cfg_q,
    output logic         armed_q
);
    // Shift register holding the whole configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_en)
            cfg_q <= {cfg_q[W-2:0], cfg_bit};
    end

    // Sticky arming flag, set by the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (cfg_done)
            armed_q <= 1'b1;
    end

    // R2: an enabled edge moves the word up and captures the serial bit
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[0] == $past(cfg_bit) && cfg_q[W-1:1] == $past(cfg_q[W-2:0])));

    // R3: without the enable the word holds
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

    // R4: done strobe arms the outputs
    a_r4_done_arms: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> armed_q);

    // R4: arming is sticky until reset
    a_r4_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);
endmodule

// File: rtl/sop_and_plane.sv
// Programmable AND plane: each term is the AND of its connected literals.
// Per term, per input: bit 2i = true literal, bit 2i+1 = complemented literal.
// Assumes clk/rst_n are only used to sample the embedded assertions.
module sop_and_plane #(
    parameter int unsigned N_IN   = 3,
    parameter int unsigned N_TERM = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_vec,
    input  logic [2*N_IN*N_TERM-1:0]  and_cfg,
    output logic [N_TERM-1:0]         term_o
);
    localparam int unsigned LIT_W = 2 * N_IN;

    logic [N_TERM-1:0][N_IN-1:0] lit_ok;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // A connected literal must match the input; an unconnected one passes.
            assign lit_ok[t][i] = (~and_cfg[t*LIT_W + 2*i]     |  in_vec[i]) &
                                  (~and_cfg[t*LIT_W + 2*i + 1] | ~in_vec[i]);

            // R6: both literals of one input force the term low
            a_r6_conflict_kills_term: assert property (@(posedge clk) disable iff (!rst_n)
                (and_cfg[t*LIT_W + 2*i] && and_cfg[t*LIT_W + 2*i + 1]) |-> !term_o[t]);
        end

        // Product term of the connected literals.
        assign term_o[t] = &lit_ok[t];

        // R7: an empty term evaluates to 1
        a_r7_empty_term_high: assert property (@(posedge clk) disable iff (!rst_n)
            (and_cfg[t*LIT_W +: LIT_W] == '0) |-> term_o[t]);
    end
endmodule

// File: rtl/sop_or_plane.sv
// Programmable OR plane with per-output polarity and output gating.
// Output o uses or_cfg[o*N_TERM +: N_TERM]; pol_cfg[o]=1 inverts the sum.
// Assumes outputs are forced low while not armed.
module sop_or_plane #(
    parameter int unsigned N_TERM = 4,
    parameter int unsigned N_OUT  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_TERM-1:0]        terms,
    input  logic [N_TERM*N_OUT-1:0]  or_cfg,
    input  logic [N_OUT-1:0]         pol_cfg,
    input  logic                     armed,
    output logic [N_OUT-1:0]         f_out
);
    logic [N_OUT-1:0] sum;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Sum of the selected product terms.
        assign sum[o]   = |(terms & or_cfg[o*N_TERM +: N_TERM]);
        // Polarity applied after the OR term, gated by arming.
        assign f_out[o] = armed & (sum[o] ^ pol_cfg[o]);

        // R8/R9: with no term selected the output equals its polarity bit
        a_r8_empty_sum_gives_pol: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && or_cfg[o*N_TERM +: N_TERM] == '0) |-> (f_out[o] == pol_cfg[o]));
    end

    // R4: nothing reaches the outputs before arming
    a_r4_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (f_out == '0));
endmodule

// File: rtl/sop_array.sv
// Top of the configurable sum-of-products array.
// Chain -> AND plane -> OR plane with polarity; inputs to outputs combinational.
// Assumes configuration is loaded MSB first and then armed with cfg_done.
module sop_array
    import sop_array_pkg::*;
#(
    parameter int unsigned N_IN   = DEF_INPUTS,
    parameter int unsigned N_TERM = DEF_TERMS,
    parameter int unsigned N_OUT  = DEF_OUTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic             cfg_done,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] f_out
);
    localparam int unsigned AND_W   = 2 * N_IN * N_TERM;
    localparam int unsigned OR_W    = N_TERM * N_OUT;
    localparam int unsigned CFG_W   = chain_len(N_IN, N_TERM, N_OUT);
    localparam int unsigned OR_LSB  = N_OUT;
    localparam int unsigned AND_LSB = OR_LSB + OR_W;

    logic [CFG_W-1:0]  cfg_q;
    logic              armed_q;
    logic [N_TERM-1:0] terms;

    sop_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_bit  (cfg_bit),
        .cfg_done (cfg_done),
        .cfg_q    (cfg_q),
        .armed_q  (armed_q)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vec  (in_vec),
        .and_cfg (cfg_q[AND_LSB +: AND_W]),
        .term_o  (terms)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms   (terms),
        .or_cfg  (cfg_q[OR_LSB +: OR_W]),
        .pol_cfg (cfg_q[0 +: N_OUT]),
        .armed   (armed_q),
        .f_out   (f_out)
    );
endmodule

// File: tb/tb_sop_array.sv
// Self-checking bench: reference-table sweep plus directed corner cases.
module tb_sop_array;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_done = 1'b0;
    logic [2:0] in_vec = 3'b000;
    logic [1:0] f_out;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sop_array dut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
                   .cfg_done(cfg_done), .in_vec(in_vec), .f_out(f_out));

    // Reference table (R11): {A,B,C, F2,F1}
    localparam logic [4:0] REF_TAB [8] = '{
        5'b000_10, 5'b001_10, 5'b010_11, 5'b011_00,
        5'b100_11, 5'b101_01, 5'b110_10, 5'b111_01
    };

    // Bit positions from R5, R8, R9.
    function automatic int tpos(int t, int i); return 10 + 6*t + 2*i; endfunction
    function automatic int cpos(int t, int i); return 11 + 6*t + 2*i; endfunction
    function automatic int opos(int t, int o); return 2 + 4*o + t; endfunction

    function automatic logic [33:0] build_ref();
        logic [33:0] w = '0;
        w[tpos(0,2)] = 1'b1; w[cpos(0,1)] = 1'b1;                        // AB'
        w[tpos(1,2)] = 1'b1; w[tpos(1,0)] = 1'b1;                        // AC
        w[cpos(2,2)] = 1'b1; w[tpos(2,1)] = 1'b1; w[cpos(2,0)] = 1'b1;   // A'BC'
        w[tpos(3,1)] = 1'b1; w[tpos(3,0)] = 1'b1;                        // BC
        w[opos(0,0)] = 1'b1; w[opos(1,0)] = 1'b1; w[opos(2,0)] = 1'b1;
        w[opos(1,1)] = 1'b1; w[opos(3,1)] = 1'b1;
        w[1] = 1'b1;                                                     // F2 inverted
        return w;
    endfunction

    task automatic check(string req, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (in=%b)", req, got, exp, in_vec);
        end
    endtask

    task automatic load(logic [33:0] w);
        for (int k = 33; k >= 0; k--) begin
            @(negedge clk); cfg_en = 1'b1; cfg_bit = w[k];
        end
        @(negedge clk); cfg_en = 1'b0; cfg_bit = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0;
    endtask

    task automatic sweep_const(string req, logic [1:0] exp);
        for (int v = 0; v < 8; v++) begin
            in_vec = v[2:0]; #1; check(req, f_out, exp);
        end
    endtask

    // Walk the reference table with no clock edges between patterns (R10, R11).
    task automatic sweep_ref(string req);
        for (int r = 0; r < 8; r++) begin
            in_vec = REF_TAB[r][4:2]; #1; check(req, f_out, REF_TAB[r][1:0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep_const("R1 reset state", 2'b00);

        load(build_ref());
        sweep_const("R4 loaded but not armed", 2'b00);
        arm();
        sweep_ref("R11/R10/R5 reference function");

        // R3: toggle serial data with enable low
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); cfg_bit = ~cfg_bit;
        end
        cfg_bit = 1'b0;
        sweep_ref("R3 config held with enable low");

        // R7/R8: empty term on out0, nothing selected on out1 (R2 overwrite)
        begin
            logic [33:0] w = '0;
            w[opos(0,0)] = 1'b1;
            load(w);
            sweep_const("R7 empty term high, R8 empty sum low", 2'b01);
            w[1:0] = 2'b11;
            load(w);
            sweep_const("R9 both polarities inverted", 2'b10);
        end

        // R6: conflicting literals on A with B true; empty term1 unselected (R7)
        begin
            logic [33:0] w = '0;
            w[tpos(0,2)] = 1'b1; w[cpos(0,2)] = 1'b1; w[tpos(0,1)] = 1'b1;
            w[opos(0,0)] = 1'b1; w[opos(0,1)] = 1'b1;
            load(w);
            sweep_const("R6 conflict forces term low / R7 unselected empty term", 2'b00);
        end

        // R1: reset clears config and arming; re-arming gives polarity-0 zeros
        load(build_ref());
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sweep_const("R1 cleared after reset", 2'b00);
        arm();
        sweep_const("R1 config bits cleared by reset", 2'b00);

        // R4: arming is sticky
        load(build_ref());
        arm();
        repeat (20) @(negedge clk);
        sweep_ref("R4 stays armed");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule